// File: doc/BRIEF.md
# Tagged Add/Subtract Unit

This unit performs 32-bit tagged integer addition and subtraction for runtimes that keep a small type tag in the low bits of each machine word. A word whose two low bits are zero holds a small integer. When a valid strobe arrives, the unit adds or subtracts the two operands. It either commits the result and a fresh set of condition codes, or it raises a tag-overflow trap and leaves all of its architectural state unchanged.

Two conditions raise the trap: a nonzero tag on either operand, or signed overflow of the operation. The tag check does not depend on the arithmetic, so a bad tag traps whether or not the operation would also overflow. Every outcome appears on the clock edge that follows the strobe. A write-back enable pulse marks a committed result, and a trap pulse marks an aborted one.

Top module: `tag_arith_unit`

## Requirements
- R1: After reset, resData, flagN, flagZ, flagV and flagC are all 0, and resValid and trapPulse are low.
- R2: If either operand has a nonzero value in bits [1:0] when inValid is high, trapPulse is high on the next cycle. This holds for any arithmetic outcome.
- R3: For an add (inSub=0), if both operands have the same bit 31 and the result's bit 31 differs from opA's bit 31, the unit traps on the next cycle.
- R4: For a subtract (inSub=1), if the operands differ in bit 31 and the result's bit 31 differs from opA's bit 31, the unit traps on the next cycle.
- R5: When a strobe does not trap, the cycle after it shows resValid high, trapPulse low, and resData equal to opA+opB (add) or opA-opB (subtract), taken modulo 2^32.
- R6: On a trap, resValid stays low, and resData, flagN, flagZ, flagV and flagC keep the values they had before the strobe.
- R7: On a committed result, flagN equals bit 31 of the result, flagZ is 1 exactly when the result is zero, and flagV is 0.
- R8: On a committed add, flagC is the carry out of bit 31. On a committed subtract, flagC is 1 exactly when opA < opB as unsigned numbers (borrow).
- R9: A cycle that follows one with inValid low shows resValid and trapPulse low, and resData and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation strobe |
| inSub | input | 1 | 0 = add, 1 = subtract |
| opA | input | 32 | First operand (minuend for subtract) |
| opB | input | 32 | Second operand |
| resData | output | 32 | Last committed result |
| resValid | output | 1 | One-cycle write-back enable for a committed result |
| trapPulse | output | 1 | One-cycle tag-overflow trap |
| flagN | output | 1 | Negative condition code |
| flagZ | output | 1 | Zero condition code |
| flagV | output | 1 | Overflow condition code |
| flagC | output | 1 | Carry/borrow condition code |

## Verification
The assertions check the following on every cycle:
- each strobe produces exactly one outcome;
- a tagged operand always traps;
- a trap or an idle cycle leaves the flags still;
- N and Z agree with the committed result, and V stays clear.

Only the bench scenarios can show that the sums, differences and carry/borrow values are correct. These scenarios cover the signed boundaries at 0x7FFFFFFF and 0x80000000, every pairing of tag values on the two operands, and a tag fault combined with an arithmetic overflow.

// File: rtl/tag_arith_pkg.sv
package tag_arith_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic commit;
    logic trap;
  } ctlStrobe_t;

  // Condition codes
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccFlags_t;
endpackage

// File: rtl/tagArithDatapath.sv
module tagArithDatapath
  import tag_arith_pkg::*;
#(
  parameter int W        = 32,
  parameter int TAG_BITS = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inSub,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  ctlStrobe_t   strobe,
  output logic         tagBad,
  output logic         arithOvf,
  output logic [W-1:0] resData,
  output ccFlags_t     flags
);
  localparam int MSB = W - 1;
  localparam logic [W-1:0] TAG_MASK = {{(W-TAG_BITS){1'b0}}, {TAG_BITS{1'b1}}};

  logic [W:0]   wideRes;
  logic [W-1:0] rawRes;
  logic         carryOut;
  logic         sameSign;
  logic         signFlip;
  ccFlags_t     nextFlags;

  // One adder handles both operations; bit W is the carry for an add and the borrow for a subtract
  always_comb begin
    if (inSub) wideRes = {1'b0, opA} - {1'b0, opB};
    else       wideRes = {1'b0, opA} + {1'b0, opB};
  end

  assign rawRes   = wideRes[MSB:0];
  assign carryOut = wideRes[W];
  assign sameSign = ~(opA[MSB] ^ opB[MSB]);
  assign signFlip = opA[MSB] ^ rawRes[MSB];
  assign arithOvf = (inSub ? ~sameSign : sameSign) & signFlip;
  assign tagBad   = |((opA | opB) & TAG_MASK);

  always_comb begin
    nextFlags.n = rawRes[MSB];
    nextFlags.z = (rawRes == '0);
    nextFlags.v = 1'b0;
    nextFlags.c = carryOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resData <= '0;
      flags   <= '0;
    end else if (strobe.commit) begin
      resData <= rawRes;
      flags   <= nextFlags;
    end
  end
endmodule

// File: rtl/tagArithControl.sv
module tagArithControl
  import tag_arith_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       tagBad,
  input  logic       arithOvf,
  output ctlStrobe_t strobe,
  output logic       trapPulse,
  output logic       resValid
);
  logic faulted;

  // The tag fault is checked first; either fault blocks the commit
  always_comb begin
    faulted       = tagBad ? 1'b1 : arithOvf;
    strobe.trap   = inValid & faulted;
    strobe.commit = inValid & ~faulted;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trapPulse <= 1'b0;
      resValid  <= 1'b0;
    end else begin
      trapPulse <= strobe.trap;
      resValid  <= strobe.commit;
    end
  end
endmodule

// File: rtl/tag_arith_unit.sv
module tag_arith_unit
  import tag_arith_pkg::*;
#(
  parameter int W        = 32,
  parameter int TAG_BITS = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         inSub,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] resData,
  output logic         resValid,
  output logic         trapPulse,
  output logic         flagN,
  output logic         flagZ,
  output logic         flagV,
  output logic         flagC
);
  ctlStrobe_t strobe;
  ccFlags_t   flags;
  logic       tagBad;
  logic       arithOvf;

  tagArithDatapath #(.W(W), .TAG_BITS(TAG_BITS)) uDatapath (
    .clk(clk), .rstN(rstN), .inSub(inSub), .opA(opA), .opB(opB),
    .strobe(strobe), .tagBad(tagBad), .arithOvf(arithOvf),
    .resData(resData), .flags(flags)
  );

  tagArithControl uControl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .tagBad(tagBad),
    .arithOvf(arithOvf), .strobe(strobe), .trapPulse(trapPulse),
    .resValid(resValid)
  );

  assign flagN = flags.n;
  assign flagZ = flags.z;
  assign flagV = flags.v;
  assign flagC = flags.c;
endmodule

// File: rtl/tag_arith_checker.sv
module tag_arith_checker #(
  parameter int W        = 32,
  parameter int TAG_BITS = 2
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic         inSub,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic [W-1:0] resData,
  input logic         resValid,
  input logic         trapPulse,
  input logic         flagN,
  input logic         flagZ,
  input logic         flagV,
  input logic         flagC
);
  localparam logic [W-1:0] TAG_MASK = {{(W-TAG_BITS){1'b0}}, {TAG_BITS{1'b1}}};

  AST_TAG_TRAPS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (((opA | opB) & TAG_MASK) != '0)) |=> trapPulse); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (trapPulse ^ resValid)); // R5
  AST_TRAP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> ($stable({flagN, flagZ, flagV, flagC}) && $stable(resData))); // R6
  AST_NZ_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> ((flagN == resData[W-1]) && (flagZ == (resData == '0)))); // R7
  AST_V_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !flagV); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!resValid && !trapPulse && $stable({flagN, flagZ, flagV, flagC}))); // R9
endmodule

bind tag_arith_unit tag_arith_checker #(.W(W), .TAG_BITS(TAG_BITS)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inSub(inSub), .opA(opA),
  .opB(opB), .resData(resData), .resValid(resValid), .trapPulse(trapPulse),
  .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
);

// File: tb/sim_tag_arith_unit.sv
module sim_tag_arith_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inSub = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] resData;
  logic        resValid, trapPulse, flagN, flagZ, flagV, flagC;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tag_arith_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSub(inSub), .opA(opA),
    .opB(opB), .resData(resData), .resValid(resValid), .trapPulse(trapPulse),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );

  // {sub, a, b, trap, result, N, Z, C}
  localparam int NVEC = 13;
  localparam logic [100:0] VECS [NVEC] = '{
    {1'b0, 32'h00000004, 32'h00000008, 1'b0, 32'h0000000C, 3'b000},
    {1'b0, 32'h7FFFFFFC, 32'h00000004, 1'b1, 32'h00000000, 3'b000},
    {1'b0, 32'h7FFFFFF8, 32'h00000004, 1'b0, 32'h7FFFFFFC, 3'b000},
    {1'b0, 32'hFFFFFFFC, 32'h00000004, 1'b0, 32'h00000000, 3'b011},
    {1'b0, 32'h80000000, 32'hFFFFFFFC, 1'b1, 32'h00000000, 3'b000},
    {1'b0, 32'h80000000, 32'h00000004, 1'b0, 32'h80000004, 3'b100},
    {1'b1, 32'h80000000, 32'h00000004, 1'b1, 32'h00000000, 3'b000},
    {1'b1, 32'h7FFFFFFC, 32'hFFFFFFFC, 1'b1, 32'h00000000, 3'b000},
    {1'b1, 32'h00000004, 32'h00000008, 1'b0, 32'hFFFFFFFC, 3'b101},
    {1'b1, 32'h00000008, 32'h00000008, 1'b0, 32'h00000000, 3'b010},
    {1'b1, 32'h80000004, 32'h80000000, 1'b0, 32'h00000004, 3'b000},
    {1'b0, 32'h7FFFFFFD, 32'h00000004, 1'b1, 32'h00000000, 3'b000},
    {1'b1, 32'h80000001, 32'h00000004, 1'b1, 32'h00000000, 3'b000}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one strobe at a falling edge and sample at the next falling edge
  task automatic doOp(input logic sub, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    inValid = 1'b1; inSub = sub; opA = a; opB = b;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Check one outcome; on a trap the previous result and flags must survive
  task automatic checkOutcome(input string req, input bit expTrap, input logic [31:0] expRes,
                              input logic [2:0] expNZC, input logic [31:0] prevRes,
                              input logic [3:0] prevFlags);
    check(trapPulse == expTrap, {req, " trap"}, 64'(trapPulse), 64'(expTrap));
    check(resValid == !expTrap, {req, " resValid"}, 64'(resValid), 64'(!expTrap));
    if (expTrap) begin
      check(resData == prevRes, "R6 result held", 64'(resData), 64'(prevRes));
      check({flagN, flagZ, flagV, flagC} == prevFlags, "R6 flags held",
            64'({flagN, flagZ, flagV, flagC}), 64'(prevFlags));
    end else begin
      check(resData == expRes, "R5 result", 64'(resData), 64'(expRes));
      check({flagN, flagZ, flagV} == {expNZC[2], expNZC[1], 1'b0}, "R7 NZV",
            64'({flagN, flagZ, flagV}), 64'({expNZC[2], expNZC[1], 1'b0}));
      check(flagC == expNZC[0], "R8 carry/borrow", 64'(flagC), 64'(expNZC[0]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pRes;
    logic [3:0]  pFlg;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({resData, resValid, trapPulse, flagN, flagZ, flagV, flagC} == '0, "R1 reset",
          64'({resData, resValid, trapPulse, flagN, flagZ, flagV, flagC}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Vector table: boundaries around 0x7FFFFFFF/0x80000000 (R3, R4, R2 priority)
    for (int i = 0; i < NVEC; i++) begin
      logic [100:0] v;
      v = VECS[i];
      pRes = resData;
      pFlg = {flagN, flagZ, flagV, flagC};
      doOp(v[100], v[99:68], v[67:36]);
      checkOutcome(v[100] ? "R4 sub" : "R3 add", v[35], v[34:3], v[2:0], pRes, pFlg);
    end

    // R2: every tag pairing on the two operands
    for (int ta = 0; ta < 4; ta++) begin
      for (int tb = 0; tb < 4; tb++) begin
        pRes = resData;
        pFlg = {flagN, flagZ, flagV, flagC};
        doOp(1'b0, 32'h10 | 32'(ta), 32'h20 | 32'(tb));
        checkOutcome("R2 tag", (ta != 0) || (tb != 0), 32'h30, 3'b000, pRes, pFlg);
      end
    end

    // R9: idle cycles keep everything still
    doOp(1'b1, 32'h00000000, 32'h00000004);   // commit 0xFFFFFFFC, N=1 C=1
    pRes = resData;
    pFlg = {flagN, flagZ, flagV, flagC};
    @(negedge clk);
    opA = 32'h7FFFFFFC; opB = 32'h4;
    @(negedge clk);
    check(!resValid && !trapPulse, "R9 no pulse", 64'({resValid, trapPulse}), 64'd0);
    check(resData == pRes && {flagN, flagZ, flagV, flagC} == pFlg, "R9 state held",
          64'({resData, flagN, flagZ, flagV, flagC}), 64'({pRes, pFlg}));

    // R6: trap right after a nonzero-flag commit
    doOp(1'b0, 32'h7FFFFFFC, 32'h7FFFFFFC);
    checkOutcome("R3 add trap", 1'b1, 32'h0, 3'b000, pRes, pFlg);

    // R1: reset in mid-run clears state
    rstN = 1'b0;
    @(negedge clk);
    check({resData, flagN, flagZ, flagV, flagC} == '0, "R1 reset again",
          64'({resData, flagN, flagZ, flagV, flagC}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule